// File: doc/BRIEF.md
# FSK Tag Demodulator and Frame Decoder

This block pulls a tag identifier out of the sampled envelope of a 125 kHz reader field. The tag answers by switching between two subcarriers, one with a period of 8 field cycles and one with a period of 10. Each sample is sliced to one bit. The spacing between rising edges of the sliced signal says which subcarrier is present.

Runs of equal spacing class are rounded to a count of Manchester half-bits. The half-bit stream is searched for a start marker that breaks the Manchester rules. Once the marker is found, pairs of half-bits are decoded into identifier bits.

Each identifier is delivered when the marker of the following frame arrives. The block can also be told to freeze on the first identifier it finds until software releases it.

Top module: `fsk_tag_decoder`

## Requirements
- R1: A sample whose value is 127 or more slices to 1. A value of 126 or less slices to 0.
- R2: The gap between two rising edges is counted in accepted samples. A gap of 8 or less gives symbol 1 (short subcarrier); a gap of 9 or more gives symbol 0. The first gap after reset is not classified.
- R3: When the symbol class changes, the run length just ended is rounded to half-bits as (run+1)/6 for symbol 1 and (run+1)/5 for symbol 0. A half-bit of value 1 lasting 7 short cycles still decodes as one half-bit.
- R4: A rounded count of 0 or 1 yields one half-bit, and a count of 2 to 4 yields that many. A count above 4 yields no half-bit at all.
- R5: The half-bit sequence 1,1,1,0,0,0 (oldest first) is a start marker. It clears the identifier register and locks framing, and the next two half-bits form the first data pair.
- R6: While locked, pair 0,1 decodes to bit 1 and pair 1,0 to bit 0. Each bit enters at bit 0 of a 64-bit register, so after more than 64 bits the register holds the last 64 sent, with the first-sent bit highest.
- R7: A locked pair of 0,0 or 1,1 clears the register and drops lock. No identifier is then reported at the next marker.
- R8: At a start marker with a nonzero register, `id_valid` pulses for one cycle and `id_value` takes the register value and keeps it. A zero register gives no pulse. After reset, `id_valid`, `id_held` and `id_value` are all zero.
- R9: With `find_one` high, the first report sets `id_held`. While held, no further report occurs and `id_value` is frozen. A `hold_clear` pulse releases the hold and restarts the marker search.
- R10: Cycles with `smp_valid` low are ignored, whatever `smp_data` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SMP_W (8) | Unsigned envelope sample |
| find_one | input | 1 | Freeze on the first reported identifier |
| hold_clear | input | 1 | Release the hold and restart the frame search |
| id_valid | output | 1 | One-cycle pulse with a new identifier |
| id_value | output | ID_W (64) | Last reported identifier |
| id_held | output | 1 | An identifier is frozen |

## Verification
The assertions check these rules on every cycle:
- a classification only follows an accepted sample;
- every half-bit burst carries 1 to 4 half-bits and fits the half-bit queue;
- reports are single-cycle and never zero;
- nothing changes on the identifier port while a hold is active.

Only the bench scenarios can show the following:
- the slicing threshold and the 8/9 gap split;
- the rounding of runs and the dropping of runs that are too long;
- the Manchester pairing after a marker;
- the clearing on an invalid pair;
- the silence on an all-zero frame;
- the register contents after an overlong frame.

// File: rtl/fskd_pkg.sv
package fskd_pkg;
  // largest half-bit count a single run may produce
  localparam int HB_MAX = 4;
  // start marker, oldest half-bit in the top bit
  localparam logic [5:0] SOF_PATTERN = 6'b111000;

  typedef struct packed {
    logic       val;  // half-bit value (1 = short subcarrier)
    logic [2:0] cnt;  // number of half-bits, 1..HB_MAX
  } hb_burst_t;
endpackage

// File: rtl/fskd_edge_class.sv
module fskd_edge_class #(
  parameter int SMP_W     = 8,
  parameter int THRESH    = 127,
  parameter int SHORT_MAX = 8,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_data,
  output logic             cls_valid,
  output logic             cls_sym
);
  localparam logic [SMP_W-1:0] THR  = SMP_W'(THRESH);
  localparam logic [CNT_W-1:0] LIM  = CNT_W'(SHORT_MAX);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic             prev_bit;
  logic             armed;
  logic             bit_now;
  logic             rise;
  logic [CNT_W-1:0] gap_cnt;

  assign bit_now = (smp_data >= THR);
  assign rise    = bit_now & ~prev_bit;

  // gap_cnt holds the distance in samples back to the last rising edge
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_bit  <= 1'b1;
      armed     <= 1'b0;
      gap_cnt   <= '0;
      cls_valid <= 1'b0;
      cls_sym   <= 1'b0;
    end else begin
      cls_valid <= 1'b0;
      if (smp_valid) begin
        prev_bit <= bit_now;
        if (rise) begin
          if (armed) begin
            cls_valid <= 1'b1;
            cls_sym   <= (gap_cnt <= LIM);
          end
          armed   <= 1'b1;
          gap_cnt <= CNT_W'(1);
        end else if (gap_cnt != CMAX) begin
          gap_cnt <= gap_cnt + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/fskd_run_round.sv
module fskd_run_round
  import fskd_pkg::*;
#(
  parameter int RUN_W     = 8,
  parameter int FC8_HALF  = 6,
  parameter int FC10_HALF = 5
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      cls_valid,
  input  logic      cls_sym,
  output logic      burst_valid,
  output hb_burst_t burst
);
  localparam int NW = RUN_W + 1;
  localparam logic [RUN_W-1:0] RMAX = '1;

  logic             have_run;
  logic             cur_sym;
  logic [RUN_W-1:0] run_len;
  logic [NW-1:0]    run_p1;
  logic [NW-1:0]    halves;
  logic [2:0]       hb_n;

  assign run_p1 = {1'b0, run_len} + NW'(1);
  assign halves = cur_sym ? (run_p1 / NW'(FC8_HALF)) : (run_p1 / NW'(FC10_HALF));

  always_comb begin
    if (halves <= NW'(1))          hb_n = 3'd1;
    else if (halves <= NW'(HB_MAX)) hb_n = halves[2:0];
    else                           hb_n = 3'd0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      have_run    <= 1'b0;
      cur_sym     <= 1'b0;
      run_len     <= '0;
      burst_valid <= 1'b0;
      burst       <= '0;
    end else begin
      burst_valid <= 1'b0;
      if (cls_valid) begin
        if (!have_run) begin
          have_run <= 1'b1;
          cur_sym  <= cls_sym;
          run_len  <= RUN_W'(1);
        end else if (cls_sym == cur_sym) begin
          if (run_len != RMAX) run_len <= run_len + RUN_W'(1);
        end else begin
          burst_valid <= (hb_n != 3'd0);
          burst.val   <= cur_sym;
          burst.cnt   <= hb_n;
          cur_sym     <= cls_sym;
          run_len     <= RUN_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/fskd_hb_queue.sv
module fskd_hb_queue
  import fskd_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_valid,
  input  hb_burst_t     push,
  output logic          out_valid,
  output logic          out_bit,
  output logic [LW-1:0] level
);
  logic [DEPTH-1:0] q;
  logic [DEPTH-1:0] q_sh;
  logic [DEPTH-1:0] q_n;
  logic [LW-1:0]    base;
  logic [LW-1:0]    level_n;
  logic             pop;

  assign pop       = (level != '0);
  assign base      = level - LW'(pop);
  assign q_sh      = pop ? (q >> 1) : q;
  assign out_valid = pop;
  assign out_bit   = q[0];

  // pop one half-bit per cycle, append a whole burst behind the survivors
  always_comb begin
    int top_i;
    top_i = int'(base) + (push_valid ? int'(push.cnt) : 0);
    if (top_i > DEPTH) top_i = DEPTH;
    for (int i = 0; i < DEPTH; i++) begin
      if (i < int'(base))  q_n[i] = q_sh[i];
      else if (i < top_i)  q_n[i] = push.val;
      else                 q_n[i] = 1'b0;
    end
    level_n = LW'(top_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= '0;
      level <= '0;
    end else begin
      q     <= q_n;
      level <= level_n;
    end
  end
endmodule

// File: rtl/fskd_frame_dec.sv
module fskd_frame_dec
  import fskd_pkg::*;
#(
  parameter int ID_W = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hb_valid,
  input  logic            hb_bit,
  input  logic            find_one,
  input  logic            hold_clear,
  output logic            id_valid,
  output logic [ID_W-1:0] id_value,
  output logic            id_held
);
  logic [5:0]      win;
  logic [5:0]      w_n;
  logic [2:0]      fill;
  logic [2:0]      f_n;
  logic            locked;
  logic [ID_W-1:0] shreg;

  assign w_n = {win[4:0], hb_bit};
  assign f_n = fill + 3'd1;

  // a decision is taken only with six half-bits in view (oldest = w_n[5])
  always_ff @(posedge clk) begin
    if (rst) begin
      win      <= '0;
      fill     <= '0;
      locked   <= 1'b0;
      shreg    <= '0;
      id_valid <= 1'b0;
      id_value <= '0;
      id_held  <= 1'b0;
    end else begin
      id_valid <= 1'b0;
      if (hold_clear) begin
        id_held <= 1'b0;
        locked  <= 1'b0;
        shreg   <= '0;
        fill    <= '0;
        win     <= '0;
      end else if (hb_valid && !id_held) begin
        win <= w_n;
        if (f_n != 3'd6) begin
          fill <= f_n;
        end else if (w_n == SOF_PATTERN) begin
          fill   <= 3'd0;
          locked <= 1'b1;
          shreg  <= '0;
          if (shreg != '0) begin
            id_valid <= 1'b1;
            id_value <= shreg;
            if (find_one) id_held <= 1'b1;
          end
        end else if (locked) begin
          fill <= 3'd4;
          if (w_n[5] != w_n[4]) begin
            shreg <= {shreg[ID_W-2:0], w_n[4]};
          end else begin
            shreg  <= '0;
            locked <= 1'b0;
          end
        end else begin
          fill <= 3'd5;
        end
      end
    end
  end
endmodule

// File: rtl/fsk_tag_decoder.sv
module fsk_tag_decoder
  import fskd_pkg::*;
#(
  parameter  int SMP_W     = 8,
  parameter  int THRESH    = 127,
  parameter  int SHORT_MAX = 8,
  parameter  int CNT_W     = 8,
  parameter  int RUN_W     = 8,
  parameter  int FC8_HALF  = 6,
  parameter  int FC10_HALF = 5,
  parameter  int Q_DEPTH   = 8,
  parameter  int ID_W      = 64,
  localparam int Q_LW      = $clog2(Q_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_data,
  input  logic             find_one,
  input  logic             hold_clear,
  output logic             id_valid,
  output logic [ID_W-1:0]  id_value,
  output logic             id_held
);
  logic            cls_valid;
  logic            cls_sym;
  logic            burst_valid;
  hb_burst_t       burst;
  logic            hb_valid;
  logic            hb_bit;
  logic [Q_LW-1:0] q_level;

  fskd_edge_class #(
    .SMP_W(SMP_W), .THRESH(THRESH), .SHORT_MAX(SHORT_MAX), .CNT_W(CNT_W)
  ) u_edge (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .cls_valid(cls_valid), .cls_sym(cls_sym)
  );

  fskd_run_round #(
    .RUN_W(RUN_W), .FC8_HALF(FC8_HALF), .FC10_HALF(FC10_HALF)
  ) u_run (
    .clk(clk), .rst(rst), .cls_valid(cls_valid), .cls_sym(cls_sym),
    .burst_valid(burst_valid), .burst(burst)
  );

  fskd_hb_queue #(
    .DEPTH(Q_DEPTH)
  ) u_queue (
    .clk(clk), .rst(rst), .push_valid(burst_valid), .push(burst),
    .out_valid(hb_valid), .out_bit(hb_bit), .level(q_level)
  );

  fskd_frame_dec #(
    .ID_W(ID_W)
  ) u_frame (
    .clk(clk), .rst(rst), .hb_valid(hb_valid), .hb_bit(hb_bit),
    .find_one(find_one), .hold_clear(hold_clear),
    .id_valid(id_valid), .id_value(id_value), .id_held(id_held)
  );
endmodule

// File: rtl/fskd_checker.sv
module fskd_checker #(
  parameter int ID_W    = 64,
  parameter int Q_DEPTH = 8,
  parameter int Q_LW    = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            smp_valid,
  input logic            cls_valid,
  input logic            burst_valid,
  input logic [2:0]      burst_cnt,
  input logic [Q_LW-1:0] q_level,
  input logic            id_valid,
  input logic [ID_W-1:0] id_value,
  input logic            id_held,
  input logic            hold_clear
);
  p_class_after_sample_r10: assert property (@(posedge clk) disable iff (rst)
    cls_valid |-> $past(smp_valid));

  p_burst_range_r4: assert property (@(posedge clk) disable iff (rst)
    burst_valid |-> (burst_cnt >= 3'd1 && burst_cnt <= 3'd4));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    burst_valid |-> (int'(q_level) - int'(q_level != '0) + int'(burst_cnt) <= Q_DEPTH));

  p_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    id_valid |=> !id_valid);

  p_nonzero_report_r8: assert property (@(posedge clk) disable iff (rst)
    id_valid |-> (id_value != '0));

  p_hold_freeze_r9: assert property (@(posedge clk) disable iff (rst)
    (id_held && !hold_clear) |=> (!id_valid && $stable(id_value)));
endmodule

bind fsk_tag_decoder fskd_checker #(
  .ID_W(ID_W), .Q_DEPTH(Q_DEPTH), .Q_LW(Q_LW)
) u_fskd_chk (
  .clk(clk), .rst(rst), .smp_valid(smp_valid), .cls_valid(cls_valid),
  .burst_valid(burst_valid), .burst_cnt(burst.cnt), .q_level(q_level),
  .id_valid(id_valid), .id_value(id_value), .id_held(id_held),
  .hold_clear(hold_clear)
);

// File: tb/fsk_tag_decoder_bench.sv
`timescale 1ns/1ps
module fsk_tag_decoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic [7:0]  smp_data = 8'd0;
  logic        find_one = 1'b0;
  logic        hold_clear = 1'b0;
  logic        id_valid;
  logic [63:0] id_value;
  logic        id_held;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // waveform knobs
  int p8, p10, n8, n10;
  logic [7:0] hi_lvl, lo_lvl;
  bit gap_mode;

  logic [63:0] rep [8];
  int rep_n = 0;

  always #2 clk = ~clk;

  fsk_tag_decoder u_fsk_tag_decoder (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .find_one(find_one), .hold_clear(hold_clear),
    .id_valid(id_valid), .id_value(id_value), .id_held(id_held)
  );

  always @(negedge clk) begin
    if (!rst && id_valid) begin
      if (rep_n < 8) rep[rep_n] = id_value;
      rep_n = rep_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; smp_valid = 1'b0; find_one = 1'b0; hold_clear = 1'b0;
    p8 = 8; p10 = 10; n8 = 6; n10 = 5; hi_lvl = 8'd200; lo_lvl = 8'd20; gap_mode = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    rep_n = 0;
    @(negedge clk);
  endtask

  task automatic put(input bit v);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data  = v ? hi_lvl : lo_lvl;
    if (gap_mode) begin
      @(negedge clk);
      smp_valid = 1'b0;
      smp_data  = v ? lo_lvl : hi_lvl;
    end
  endtask

  task automatic fcyc(input int per, input int ones);
    for (int i = 0; i < per; i++) put(i < ones);
  endtask

  task automatic half(input bit v);
    if (v) repeat (n8) fcyc(p8, 2);
    else   repeat (n10) fcyc(p10, 3);
  endtask

  task automatic bitm(input bit b);
    if (b) begin half(1'b0); half(1'b1); end
    else   begin half(1'b1); half(1'b0); end
  endtask

  task automatic marker();
    repeat (3) half(1'b1);
    repeat (3) half(1'b0);
  endtask

  task automatic send_bits(input logic [63:0] v, input int nb);
    for (int i = nb - 1; i >= 0; i--) bitm(v[i]);
  endtask

  task automatic send_frame(input logic [63:0] v, input int nb);
    marker();
    send_bits(v, nb);
  endtask

  task automatic preamble();
    bitm(1'b1); bitm(1'b0); bitm(1'b0);
  endtask

  task automatic tail();
    marker();
    bitm(1'b1); bitm(1'b0); bitm(1'b1);
    @(negedge clk);
    smp_valid = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  task automatic expect_reports(input string req, input int n,
                                input logic [63:0] e0, input logic [63:0] e1);
    chk(rep_n == n, req, "report count", 64'(rep_n), 64'(n));
    if (n >= 1 && rep_n >= 1) chk(rep[0] == e0, req, "first id", rep[0], e0);
    if (n >= 2 && rep_n >= 2) chk(rep[1] == e1, req, "second id", rep[1], e1);
  endtask

  task automatic t_reset();
    do_reset();
    chk(id_valid == 1'b0, "R8", "reset id_valid", 64'(id_valid), 64'd0);
    chk(id_held == 1'b0, "R8", "reset id_held", 64'(id_held), 64'd0);
    chk(id_value == 64'd0, "R8", "reset id_value", id_value, 64'd0);
  endtask

  task automatic t_basic();  // R5 R6 R8
    do_reset();
    preamble();
    send_frame(64'h0000_02C4_7A19_B3E5, 44);
    send_frame(64'h0000_0D08_6F5C_1A2B, 44);
    tail();
    expect_reports("R6", 2, 64'h0000_02C4_7A19_B3E5, 64'h0000_0D08_6F5C_1A2B);
    chk(id_value == 64'h0000_0D08_6F5C_1A2B, "R8", "id_value kept", id_value, 64'h0000_0D08_6F5C_1A2B);
  endtask

  task automatic t_threshold();
    do_reset();
    hi_lvl = 8'd127; lo_lvl = 8'd126;
    preamble();
    send_frame(64'h0000_0123_4567_89AB, 44);
    tail();
    expect_reports("R1", 1, 64'h0000_0123_4567_89AB, 64'd0);
  endtask

  task automatic t_periods();
    do_reset();
    p8 = 7; p10 = 9;
    preamble();
    send_frame(64'h0000_0FED_CBA9_8765, 44);
    tail();
    expect_reports("R2", 1, 64'h0000_0FED_CBA9_8765, 64'd0);
  endtask

  task automatic t_rounding();
    do_reset();
    n8 = 7;
    preamble();
    send_frame(64'h0000_0A5C_3E1B_7D29, 44);
    tail();
    expect_reports("R3", 1, 64'h0000_0A5C_3E1B_7D29, 64'd0);
  endtask

  task automatic t_zero_id();
    do_reset();
    preamble();
    send_frame(64'd0, 44);
    send_frame(64'h0000_0555_AAAA_5555, 44);
    tail();
    expect_reports("R8", 1, 64'h0000_0555_AAAA_5555, 64'd0);
  endtask

  task automatic t_invalid_pair();
    do_reset();
    preamble();
    marker();
    send_bits(64'h5A5, 12);
    half(1'b0); half(1'b0);  // pair 0,0 while locked
    send_bits(64'h3C3, 12);
    send_frame(64'h0000_0369_CF03_69CF, 44);
    tail();
    expect_reports("R7", 1, 64'h0000_0369_CF03_69CF, 64'd0);
  endtask

  task automatic t_long_run();
    do_reset();
    preamble();
    send_frame(64'h0000_0ABC_DEF0_1235, 44);
    repeat (6) half(1'b0);   // rounds to 6 half-bits: must be dropped
    tail();
    expect_reports("R4", 1, 64'h0000_0ABC_DEF0_1235, 64'd0);
  endtask

  task automatic t_gaps();
    do_reset();
    gap_mode = 1'b1;
    preamble();
    send_frame(64'h0000_07E1_5A3C_96F1, 44);
    tail();
    expect_reports("R10", 1, 64'h0000_07E1_5A3C_96F1, 64'd0);
  endtask

  task automatic t_find_one();
    do_reset();
    find_one = 1'b1;
    preamble();
    send_frame(64'h0000_0111_2222_3333, 44);
    send_frame(64'h0000_0444_5555_6666, 44);
    tail();
    expect_reports("R9", 1, 64'h0000_0111_2222_3333, 64'd0);
    chk(id_held == 1'b1, "R9", "held flag", 64'(id_held), 64'd1);
    chk(id_value == 64'h0000_0111_2222_3333, "R9", "frozen id", id_value, 64'h0000_0111_2222_3333);
    @(negedge clk); hold_clear = 1'b1;
    @(negedge clk); hold_clear = 1'b0; find_one = 1'b0;
    @(negedge clk);
    chk(id_held == 1'b0, "R9", "released", 64'(id_held), 64'd0);
    send_frame(64'h0000_0777_8888_9999, 44);
    tail();
    chk(rep_n == 2, "R9", "count after release", 64'(rep_n), 64'd2);
    if (rep_n >= 2) chk(rep[1] == 64'h0000_0777_8888_9999, "R9", "id after release", rep[1], 64'h0000_0777_8888_9999);
  endtask

  task automatic t_long_frame();
    do_reset();
    preamble();
    marker();
    send_bits(64'h2D, 6);
    send_bits(64'hC3A5_96F0_1E2D_4B87, 64);
    tail();
    expect_reports("R6", 1, 64'hC3A5_96F0_1E2D_4B87, 64'd0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_threshold();
    t_periods();
    t_rounding();
    t_zero_id();
    t_invalid_pair();
    t_long_run();
    t_gaps();
    t_find_one();
    t_long_frame();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule